// File: doc/BRIEF.md
# Serial Field Memory Write Controller

This block runs the write side of a serial field memory. On every rising edge of the write clock it samples three control pins and a data word. From them it produces a write address, a write strobe and write data for a synchronous storage array that sits beside it. The pointer starts from zero after a write-pointer reset. It steps through the array and wraps back to zero after the last location, so the memory acts as a delay line whose length is set by when reset is applied.

There are two separate enables. The pointer enable halts the address entirely while it is inactive. The data enable only suppresses the store, and the pointer keeps stepping. This lets selected locations of a field be overwritten while the rest keep their old contents.

Two strap inputs set the operating mode. The polarity strap chooses whether the controls are active high or active low. The cascade strap adds one cycle of latency to the whole control and data path, so that devices can be chained. The block also counts the storing cycles between pointer resets and flags a reset that arrives before the minimum count has been reached.

Top module: `fmem_wr_ctrl`

## Requirements
- R1: The first edge that samples an active pointer reset sets the pointer to zero and issues no store, whatever the two enables are. The next store goes to address 0.
- R2: A reset is recognised only if the reset pin was sampled inactive on at least the two previous edges. A reset sampled sooner, or a reset held across several edges, acts as an ordinary cycle that follows the two enables.
- R3: When both enables are active, the cycle stores the data at the current pointer (mem_we high, mem_addr equal to the pointer) and the pointer then advances by one.
- R4: When the pointer enable is active and the data enable is inactive, no store is issued but the pointer still advances. The next store lands one address further on.
- R5: When the pointer enable is inactive, no store is issued and the pointer holds, whatever the data enable is.
- R6: With strap_pol at 0 the three controls are active when 1. With strap_pol at 1 they are active when 0.
- R7: With strap_casc at 0, a cycle sampled at edge k appears on mem_we, mem_addr and mem_wdata right after edge k. With strap_casc at 1 it appears right after edge k+1.
- R8: After address DEPTH-1 the pointer wraps to address 0.
- R9: short_err is high for exactly one cycle, in the cycle a reset takes effect, when fewer than MIN_ACTIVE storing cycles came between that reset and the previously recognised reset. It stays low at exactly MIN_ACTIVE cycles or more, and it stays low on the first reset after rst_n.
- R10: While rst_n is low and right after it is released, mem_we and short_err are 0 and mem_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial write clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| strap_pol | input | 1 | Control polarity strap (0 = active high) |
| strap_casc | input | 1 | Cascade strap (1 = one extra cycle of latency) |
| wr_rst | input | 1 | Write pointer reset request |
| wr_en | input | 1 | Pointer enable: holds the pointer and blocks storing when inactive |
| in_en | input | 1 | Data enable: masks the store only |
| din | input | DATA_W | Write data |
| mem_we | output | 1 | Store strobe to the array |
| mem_addr | output | ADDR_W | Store address to the array |
| mem_wdata | output | DATA_W | Store data to the array |
| short_err | output | 1 | One-cycle pulse on a reset that came too early |

## Verification
A pointer that is off by one does not show up in the cycle where it goes wrong. It shows up on mem_addr at the next store, which may be several cycles later if masked or halted cycles come in between. For that reason the scenarios always end with a store whose address is checked. A fault in the recognition of resets shows up within one cycle as a store where none was expected, or as a missing return to address 0. A fault in the cycle counter shows up only at the next recognised reset, through short_err.

// File: rtl/fmem_wr_pkg.sv
package fmem_wr_pkg;

   typedef struct packed {
      logic rst;
      logic we;
      logic ie;
   } wr_ctrl_t;

   function automatic int unsigned wrap_inc(input int unsigned a, input int unsigned depth);
      return (a == depth - 1) ? 0 : a + 1;
   endfunction

endpackage

// File: rtl/fmem_wr_front.sv
module fmem_wr_front
   import fmem_wr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_pol,
   input  logic              strap_casc,
   input  logic              wr_rst,
   input  logic              wr_en,
   input  logic              in_en,
   input  logic [DATA_W-1:0] din,
   output wr_ctrl_t          eff_ctrl,
   output logic [DATA_W-1:0] eff_data
);

   wr_ctrl_t          live_ctrl;
   wr_ctrl_t          dly_ctrl;
   logic [DATA_W-1:0] dly_data;

   // polarity strap: a high strap inverts every control pin
   assign live_ctrl.rst = wr_rst ^ strap_pol;
   assign live_ctrl.we  = wr_en  ^ strap_pol;
   assign live_ctrl.ie  = in_en  ^ strap_pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_ctrl <= '0;
         dly_data <= '0;
      end else begin
         dly_ctrl <= live_ctrl;
         dly_data <= din;
      end
   end

   assign eff_ctrl = strap_casc ? dly_ctrl : live_ctrl;
   assign eff_data = strap_casc ? dly_data : din;

endmodule

// File: rtl/fmem_wr_rstq.sv
module fmem_wr_rstq #(
   parameter int LOW_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic rst_ok
);

   localparam int LW = $clog2(LOW_MIN + 1);

   logic [LW-1:0] low_cnt;

   assign rst_ok = req && (low_cnt == LW'(LOW_MIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= LW'(LOW_MIN);
      else if (req)
         low_cnt <= '0;
      else if (low_cnt != LW'(LOW_MIN))
         low_cnt <= low_cnt + 1'b1;
   end

endmodule

// File: rtl/fmem_wr_actcnt.sv
module fmem_wr_actcnt #(
   parameter int MIN_ACTIVE = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_ok,
   input  logic act,
   output logic short_err
);

   localparam int CW = $clog2(MIN_ACTIVE + 1);

   logic [CW-1:0] act_cnt;
   logic          seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cnt   <= '0;
         seen      <= 1'b0;
         short_err <= 1'b0;
      end else if (rst_ok) begin
         short_err <= seen && (act_cnt < CW'(MIN_ACTIVE));
         seen      <= 1'b1;
         act_cnt   <= '0;
      end else begin
         short_err <= 1'b0;
         if (act && act_cnt < CW'(MIN_ACTIVE))
            act_cnt <= act_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/fmem_wr_ptr.sv
module fmem_wr_ptr
   import fmem_wr_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_ok,
   input  logic              we,
   input  logic              ie,
   input  logic [DATA_W-1:0] data,
   output logic [ADDR_W-1:0] ptr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);

   localparam bit POW2 = (DEPTH == (1 << ADDR_W));

   logic [ADDR_W-1:0] ptr_inc;

   generate
      if (POW2) begin : g_pow2
         assign ptr_inc = ptr + 1'b1;
      end else begin : g_cmp
         assign ptr_inc = ADDR_W'(wrap_inc(int'(ptr), DEPTH));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (rst_ok) begin
         ptr    <= '0;
         mem_we <= 1'b0;
      end else if (we) begin
         ptr      <= ptr_inc;
         mem_addr <= ptr;
         mem_we   <= ie;
         if (ie)
            mem_wdata <= data;
      end else begin
         mem_we <= 1'b0;
      end
   end

endmodule

// File: rtl/fmem_wr_ctrl.sv
module fmem_wr_ctrl
   import fmem_wr_pkg::*;
#(
   parameter int DEPTH      = 64,
   parameter int DATA_W     = 8,
   parameter int MIN_ACTIVE = 80,
   parameter int RST_GAP    = 2,
   parameter int ADDR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_pol,
   input  logic              strap_casc,
   input  logic              wr_rst,
   input  logic              wr_en,
   input  logic              in_en,
   input  logic [DATA_W-1:0] din,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              short_err
);

   initial begin
      if (DEPTH < 2)           $error("DEPTH must be at least 2");
      if (DATA_W < 1)          $error("DATA_W must be at least 1");
      if (MIN_ACTIVE < 1)      $error("MIN_ACTIVE must be at least 1");
      if (RST_GAP < 1)         $error("RST_GAP must be at least 1");
      if ((1 << ADDR_W) < DEPTH) $error("ADDR_W too small for DEPTH");
   end

   wr_ctrl_t          eff_ctrl;
   logic [DATA_W-1:0] eff_data;
   logic              rst_ok;
   logic [ADDR_W-1:0] ptr;

   fmem_wr_front #(.DATA_W(DATA_W)) u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_pol  (strap_pol),
      .strap_casc (strap_casc),
      .wr_rst     (wr_rst),
      .wr_en      (wr_en),
      .in_en      (in_en),
      .din        (din),
      .eff_ctrl   (eff_ctrl),
      .eff_data   (eff_data)
   );

   fmem_wr_rstq #(.LOW_MIN(RST_GAP)) u_rstq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (eff_ctrl.rst),
      .rst_ok (rst_ok)
   );

   fmem_wr_actcnt #(.MIN_ACTIVE(MIN_ACTIVE)) u_actcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_ok    (rst_ok),
      .act       (eff_ctrl.we & eff_ctrl.ie),
      .short_err (short_err)
   );

   fmem_wr_ptr #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_ok    (rst_ok),
      .we        (eff_ctrl.we),
      .ie        (eff_ctrl.ie),
      .data      (eff_data),
      .ptr       (ptr),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

endmodule

// File: rtl/fmem_wr_chk.sv
module fmem_wr_chk #(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_ok,
   input logic              e_we,
   input logic              e_ie,
   input logic [ADDR_W-1:0] ptr,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              short_err
);

   assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ok |=> (ptr == '0) && !mem_we);

   assert_reset_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ok |=> !rst_ok);

   assert_store_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_ok && e_we && e_ie) |=> mem_we && (mem_addr == $past(ptr)));

   assert_masked_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_ok && e_we && !e_ie) |=> !mem_we);

   assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_ok && !e_we) |=> !mem_we && $stable(ptr));

   assert_advance_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_ok && e_we) |=>
         (ptr == (($past(ptr) == ADDR_W'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)));

   assert_err_on_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      short_err |-> $past(rst_ok));

   always @(posedge clk) begin
      if (!rst_n)
         assert_idle_in_reset_R10: assert (!mem_we && !short_err);
   end

endmodule

bind fmem_wr_ctrl fmem_wr_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rst_ok    (rst_ok),
   .e_we      (eff_ctrl.we),
   .e_ie      (eff_ctrl.ie),
   .ptr       (ptr),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .short_err (short_err)
);

// File: tb/test_fmem_wr_ctrl.sv
`timescale 1ns/1ps
module test_fmem_wr_ctrl;

   localparam int DEPTH  = 64;
   localparam int DATA_W = 8;
   localparam int MINACT = 80;
   localparam int ADDR_W = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              strap_pol = 1'b0;
   logic              strap_casc = 1'b0;
   logic              wr_rst = 1'b0;
   logic              wr_en = 1'b0;
   logic              in_en = 1'b0;
   logic [DATA_W-1:0] din = '0;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              short_err;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   fmem_wr_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .MIN_ACTIVE(MINACT)) i_fmem_wr_ctrl (
      .clk(clk), .rst_n(rst_n), .strap_pol(strap_pol), .strap_casc(strap_casc),
      .wr_rst(wr_rst), .wr_en(wr_en), .in_en(in_en), .din(din),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .short_err(short_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle with logical control values; pins follow the polarity strap
   task automatic tick(input bit r, input bit we, input bit ie, input int d);
      wr_rst = r ^ strap_pol;
      wr_en  = we ^ strap_pol;
      in_en  = ie ^ strap_pol;
      din    = DATA_W'(d);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic por(input bit pol, input bit casc);
      @(negedge clk);
      rst_n = 1'b0;
      strap_pol = pol;
      strap_casc = casc;
      wr_rst = pol; wr_en = pol; in_en = pol;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_state;
      por(1'b0, 1'b0);
      chk("R10 mem_we", int'(mem_we), 0);
      chk("R10 mem_addr", int'(mem_addr), 0);
      chk("R10 short_err", int'(short_err), 0);
   endtask

   task automatic t_enables;
      por(1'b0, 1'b0);
      tick(1, 1, 1, 8'h11);
      chk("R1 no store in reset cycle", int'(mem_we), 0);
      chk("R9 no err on first reset", int'(short_err), 0);
      tick(0, 1, 1, 8'hA0);
      chk("R1 first store we", int'(mem_we), 1);
      chk("R1 first store addr", int'(mem_addr), 0);
      chk("R3 data", int'(mem_wdata), 8'hA0);
      tick(0, 1, 1, 8'hA1);
      chk("R3 addr advances", int'(mem_addr), 1);
      tick(0, 1, 0, 8'hFF);
      chk("R4 masked no store", int'(mem_we), 0);
      tick(0, 1, 1, 8'hA3);
      chk("R4 pointer advanced past mask", int'(mem_addr), 3);
      tick(0, 0, 1, 8'hEE);
      chk("R5 halted no store", int'(mem_we), 0);
      tick(0, 0, 0, 8'hEE);
      tick(0, 1, 1, 8'hA4);
      chk("R5 pointer held", int'(mem_addr), 4);
      chk("R5 data after halt", int'(mem_wdata), 8'hA4);
   endtask

   task automatic t_spacing;
      por(1'b0, 1'b0);
      tick(1, 0, 0, 0);
      tick(0, 1, 1, 1);
      tick(1, 1, 1, 2);
      chk("R2 early reset acts as store", int'(mem_we), 1);
      chk("R2 early reset addr", int'(mem_addr), 1);
      tick(0, 1, 1, 3);
      tick(0, 1, 1, 4);
      chk("R2 addr continues", int'(mem_addr), 3);
      tick(1, 1, 1, 5);
      chk("R2 spaced reset no store", int'(mem_we), 0);
      chk("R9 err on short sequence", int'(short_err), 1);
      tick(1, 1, 1, 6);
      chk("R2 held reset acts as store", int'(mem_addr), 0);
      chk("R9 err one cycle", int'(short_err), 0);
   endtask

   task automatic t_count;
      por(1'b0, 1'b0);
      tick(1, 0, 0, 0);
      for (int i = 0; i < MINACT - 1; i++) begin
         tick(0, 1, 1, i);
         tick(0, 1, 0, 0);
      end
      tick(1, 0, 0, 0);
      chk("R9 err at MIN-1", int'(short_err), 1);
      tick(0, 0, 0, 0);
      chk("R9 err pulse ends", int'(short_err), 0);
      for (int i = 0; i < MINACT; i++) tick(0, 1, 1, i);
      tick(1, 0, 0, 0);
      chk("R9 no err at MIN", int'(short_err), 0);
   endtask

   task automatic t_wrap;
      por(1'b0, 1'b0);
      tick(1, 0, 0, 0);
      for (int i = 0; i < DEPTH; i++) tick(0, 1, 1, i);
      chk("R8 last addr", int'(mem_addr), DEPTH - 1);
      tick(0, 1, 1, 8'h5A);
      chk("R8 wrap to zero", int'(mem_addr), 0);
   endtask

   task automatic t_polarity;
      por(1'b1, 1'b0);
      tick(1, 0, 0, 0);
      tick(0, 1, 1, 8'hC0);
      chk("R6 active-low store", int'(mem_we), 1);
      chk("R6 active-low addr", int'(mem_addr), 0);
      wr_rst = 1'b1; wr_en = 1'b1; in_en = 1'b1; din = 8'h77;
      @(posedge clk); @(negedge clk);
      chk("R6 high pins inactive", int'(mem_we), 0);
      tick(0, 1, 1, 8'hC1);
      chk("R6 pointer held by high pin", int'(mem_addr), 1);
   endtask

   task automatic t_cascade;
      por(1'b0, 1'b1);
      tick(1, 0, 0, 0);
      tick(0, 1, 1, 8'hD0);
      chk("R7 no store yet", int'(mem_we), 0);
      tick(0, 1, 1, 8'hD1);
      chk("R7 delayed store", int'(mem_we), 1);
      chk("R7 delayed data", int'(mem_wdata), 8'hD0);
      chk("R7 delayed addr", int'(mem_addr), 0);
      tick(0, 0, 0, 0);
      chk("R7 second data", int'(mem_wdata), 8'hD1);
      tick(0, 0, 0, 0);
      chk("R7 halt delayed", int'(mem_we), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=0", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset_state;
      t_enables;
      t_spacing;
      t_count;
      t_wrap;
      t_polarity;
      t_cascade;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule